// File: doc/BRIEF.md
# Shared-Line GPIO Interrupt Router

This block takes the per-pin interrupt levels of three GPIO ports (A with 14 pins, B with 24 pins, C with 32 pins) and folds them onto 41 input lines of an interrupt controller. Ports A and B own most of the direct lines. Port C has no lines of its own. Instead, a 32-bit select register decides, one line at a time, whether each of the first 32 lines carries port C's pin or the pin of port A or B. Any pin that is not given a direct line is still reported through its port's summary line.

Software writes the select register through a one-cycle write strobe and can read its current value back at any time. The interrupt inputs are levels, not a stream. There is no back-pressure: every line is resampled on every clock, and the outputs are registered, so a change on an input or on the select register appears on the lines one clock later. After reset the select register is zero, so port C pins reach only their summary line.

Top module: `gpio_irq_router`

## Requirements
- R1: While reset is low and on the first clock after it is released, `sel_rdata` is 0 and all 41 bits of `irq_lines` are 0.
- R2: A clock edge with `sel_wr` high loads `sel_wdata` into the select register, and `sel_rdata` shows the new value after that edge. A clock edge with `sel_wr` low leaves the register unchanged, whatever `sel_wdata` holds.
- R3: For n = 0..13, line n carries port C pin n when select bit n is 1 and port A pin n when it is 0.
- R4: For n = 14..31, line n carries port C pin n when select bit n is 1 and port B pin n-14 when it is 0.
- R5: For n = 32..37, line n always carries port B pin n-14 (pins 18..23), whatever the select register holds.
- R6: Line 38 is the OR of every port A pin n whose select bit n is 1. These are the port A pins that have lost their direct line.
- R7: Line 39 is the OR of every port B pin n (n <= 17) whose select bit n+14 is 1. Port B pins 18..23 never affect line 39.
- R8: Line 40 is the OR of every port C pin n whose select bit n is 0.
- R9: `irq_lines` is registered. The value after a clock edge is a function of the inputs and the select register as they stood at that edge. A select write therefore changes the routing one clock after the write edge.
- R10: Every asserted port C pin shows on exactly one path: its direct line when its select bit is 1, and line 40 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| porta_irq | input | 14 | Port A pin interrupt levels |
| portb_irq | input | 24 | Port B pin interrupt levels |
| portc_irq | input | 32 | Port C pin interrupt levels |
| sel_wr | input | 1 | Write strobe for the select register |
| sel_wdata | input | 32 | Value to write to the select register |
| sel_rdata | output | 32 | Current select register value |
| irq_lines | output | 41 | Registered interrupt-controller lines |

## Verification
The hardest case to reach from the ports is the cycle right after a select write. In that cycle the read-back already shows the new value, but the lines still reflect the old routing. This can hide a pin completely or report it twice. The stimulus writes new select values while input patterns are changing. It keeps a model of which select value was in force at each edge. Random writes are mixed with directed all-zero and all-one selects, and with pins driven only in the six always-direct positions of port B.

// File: rtl/gir_pkg.sv
package gir_pkg;
  // Default pin counts of the three ports.
  localparam int DEF_A_PINS = 14;
  localparam int DEF_B_PINS = 24;
  localparam int DEF_C_PINS = 32;

  // Summary-line bundle, one bit per port.
  typedef struct packed {
    logic port_c;
    logic port_b;
    logic port_a;
  } gir_sum_t;
endpackage

// File: rtl/gir_sel_reg.sv
module gir_sel_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= wdata;
  end
endmodule

// File: rtl/gir_direct_mux.sv
module gir_direct_mux #(
  parameter int A_PINS = 14,
  parameter int B_PINS = 24,
  parameter int C_PINS = 32,
  localparam int SHARED_B = C_PINS - A_PINS,
  localparam int N_DIRECT = A_PINS + B_PINS
) (
  input  logic [A_PINS-1:0]   porta,
  input  logic [B_PINS-1:0]   portb,
  input  logic [C_PINS-1:0]   portc,
  input  logic [C_PINS-1:0]   sel,
  output logic [N_DIRECT-1:0] direct
);
  // Lines shared between port A and port C.
  for (genvar i = 0; i < A_PINS; i++) begin : g_a_share
    assign direct[i] = sel[i] ? portc[i] : porta[i];
  end

  // Lines shared between the low port B pins and the upper port C pins.
  for (genvar j = 0; j < SHARED_B; j++) begin : g_b_share
    assign direct[A_PINS+j] = sel[A_PINS+j] ? portc[A_PINS+j] : portb[j];
  end

  // Port B pins that have a line of their own.
  for (genvar k = SHARED_B; k < B_PINS; k++) begin : g_b_own
    assign direct[A_PINS+k] = portb[k];
  end
endmodule

// File: rtl/gir_summary.sv
module gir_summary
  import gir_pkg::*;
#(
  parameter int A_PINS = 14,
  parameter int C_PINS = 32,
  localparam int SHARED_B = C_PINS - A_PINS
) (
  input  logic [A_PINS-1:0]   porta,
  input  logic [SHARED_B-1:0] portb_shared,
  input  logic [C_PINS-1:0]   portc,
  input  logic [C_PINS-1:0]   sel,
  output gir_sum_t            sum
);
  logic [A_PINS-1:0]   a_left;
  logic [SHARED_B-1:0] b_left;
  logic [C_PINS-1:0]   c_left;

  // Collect the pins that lost their direct line, then OR each port.
  always_comb begin
    a_left = porta & sel[A_PINS-1:0];
    b_left = portb_shared & sel[C_PINS-1:A_PINS];
    c_left = portc & ~sel;
    sum.port_a = |a_left;
    sum.port_b = |b_left;
    sum.port_c = |c_left;
  end
endmodule

// File: rtl/gir_out_reg.sv
module gir_out_reg #(
  parameter int WIDTH = 41
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import gir_pkg::*;
#(
  parameter int A_PINS = DEF_A_PINS,
  parameter int B_PINS = DEF_B_PINS,
  parameter int C_PINS = DEF_C_PINS,
  localparam int SHARED_B = C_PINS - A_PINS,
  localparam int N_DIRECT = A_PINS + B_PINS,
  localparam int N_LINES  = N_DIRECT + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [A_PINS-1:0]  porta_irq,
  input  logic [B_PINS-1:0]  portb_irq,
  input  logic [C_PINS-1:0]  portc_irq,
  input  logic               sel_wr,
  input  logic [C_PINS-1:0]  sel_wdata,
  output logic [C_PINS-1:0]  sel_rdata,
  output logic [N_LINES-1:0] irq_lines
);
  logic [C_PINS-1:0]   sel_q;
  logic [N_DIRECT-1:0] direct;
  gir_sum_t            sum;

  gir_sel_reg #(.WIDTH(C_PINS)) u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (sel_wr),
    .wdata (sel_wdata),
    .q     (sel_q)
  );

  gir_direct_mux #(.A_PINS(A_PINS), .B_PINS(B_PINS), .C_PINS(C_PINS)) u_mux (
    .porta  (porta_irq),
    .portb  (portb_irq),
    .portc  (portc_irq),
    .sel    (sel_q),
    .direct (direct)
  );

  gir_summary #(.A_PINS(A_PINS), .C_PINS(C_PINS)) u_sum (
    .porta        (porta_irq),
    .portb_shared (portb_irq[SHARED_B-1:0]),
    .portc        (portc_irq),
    .sel          (sel_q),
    .sum          (sum)
  );

  gir_out_reg #(.WIDTH(N_LINES)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sum.port_c, sum.port_b, sum.port_a, direct}),
    .q     (irq_lines)
  );

  assign sel_rdata = sel_q;
endmodule

// File: rtl/gir_checker.sv
module gir_checker #(
  parameter int A_PINS = 14,
  parameter int B_PINS = 24,
  parameter int C_PINS = 32,
  localparam int SHARED_B = C_PINS - A_PINS,
  localparam int N_DIRECT = A_PINS + B_PINS,
  localparam int N_LINES  = N_DIRECT + 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [A_PINS-1:0]  porta_irq,
  input logic [B_PINS-1:0]  portb_irq,
  input logic [C_PINS-1:0]  portc_irq,
  input logic               sel_wr,
  input logic [C_PINS-1:0]  sel_wdata,
  input logic [C_PINS-1:0]  sel_rdata,
  input logic [N_LINES-1:0] irq_lines
);
  p_sel_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> sel_rdata == $past(sel_wdata));

  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr |=> $stable(sel_rdata));

  for (genvar i = 0; i < A_PINS; i++) begin : g_a_chk
    p_a_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq_lines[i] == ($past(sel_rdata[i]) ? $past(portc_irq[i]) : $past(porta_irq[i])));
  end

  for (genvar j = 0; j < SHARED_B; j++) begin : g_b_chk
    p_b_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq_lines[A_PINS+j] ==
        ($past(sel_rdata[A_PINS+j]) ? $past(portc_irq[A_PINS+j]) : $past(portb_irq[j])));
  end

  for (genvar k = SHARED_B; k < B_PINS; k++) begin : g_own_chk
    p_own_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq_lines[A_PINS+k] == $past(portb_irq[k]));
  end

  p_sum_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_lines[N_DIRECT] == |($past(porta_irq) & $past(sel_rdata[A_PINS-1:0])));

  p_sum_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_lines[N_DIRECT+1] ==
      |($past(portb_irq[SHARED_B-1:0]) & $past(sel_rdata[C_PINS-1:A_PINS])));

  p_sum_c_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_lines[N_DIRECT+2] == |($past(portc_irq) & ~$past(sel_rdata)));

  for (genvar n = 0; n < C_PINS; n++) begin : g_c_path
    p_c_one_path_r10: assert property (@(posedge clk) disable iff (!rst_n)
      portc_irq[n] |=> ($past(sel_rdata[n]) ? irq_lines[n] : irq_lines[N_DIRECT+2]));
  end
endmodule

bind gpio_irq_router gir_checker #(.A_PINS(A_PINS), .B_PINS(B_PINS), .C_PINS(C_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .porta_irq (porta_irq),
  .portb_irq (portb_irq),
  .portc_irq (portc_irq),
  .sel_wr    (sel_wr),
  .sel_wdata (sel_wdata),
  .sel_rdata (sel_rdata),
  .irq_lines (irq_lines)
);

// File: tb/gpio_irq_router_test.sv
`timescale 1ns/1ps
module gpio_irq_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] pa = '0;
  logic [23:0] pb = '0;
  logic [31:0] pc = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [40:0] lines;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model_sel = '0;
  logic [40:0] exp_q = '0;
  bit          exp_valid = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  gpio_irq_router uut (
    .clk(clk), .rst_n(rst_n), .porta_irq(pa), .portb_irq(pb), .portc_irq(pc),
    .sel_wr(wr), .sel_wdata(wdata), .sel_rdata(rdata), .irq_lines(lines)
  );

  function automatic logic [40:0] route(logic [13:0] a, logic [23:0] b, logic [31:0] c, logic [31:0] s);
    logic [40:0] e;
    for (int i = 0; i < 14; i++) e[i] = s[i] ? c[i] : a[i];
    for (int j = 0; j < 18; j++) e[14+j] = s[14+j] ? c[14+j] : b[j];
    for (int k = 18; k < 24; k++) e[14+k] = b[k];
    e[38] = |(a & s[13:0]);
    e[39] = |(b[17:0] & s[31:14]);
    e[40] = |(c & ~s);
    return e;
  endfunction

  function automatic string req_of(int bitpos);
    if (bitpos < 14) return "R3";
    if (bitpos < 32) return "R4";
    if (bitpos < 38) return "R5";
    if (bitpos == 38) return "R6";
    if (bitpos == 39) return "R7";
    return "R8";
  endfunction

  task automatic check_lines(logic [40:0] exp);
    checks++;
    if (lines !== exp) begin
      int first = 0;
      for (int b = 40; b >= 0; b--) if (lines[b] !== exp[b]) first = b;
      fails++;
      $display("FAIL %s (R9 timing) line %0d: actual %h expected %h", req_of(first), first, lines, exp);
    end
  endtask

  task automatic check_sel(logic [31:0] exp, string req);
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s sel_rdata: actual %h expected %h", req, rdata, exp);
    end
  endtask

  // One clock: check the result of the previous cycle, then drive new inputs.
  task automatic cycle(logic w, logic [31:0] d, logic [13:0] a, logic [23:0] b, logic [31:0] c);
    @(negedge clk);
    if (exp_valid) check_lines(exp_q);
    pa = a; pb = b; pc = c; wr = w; wdata = d;
    exp_q = route(a, b, c, model_sel);
    exp_valid = 1;
    if (w) model_sel = d;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    checks++;
    if (lines !== '0 || rdata !== '0) begin
      fails++;
      $display("FAIL R1 in reset: actual %h/%h expected 0/0", lines, rdata);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (lines !== '0 || rdata !== '0) begin
      fails++;
      $display("FAIL R1 after release: actual %h/%h expected 0/0", lines, rdata);
    end

    // R8 and R3: default select, port C only reaches its summary line.
    cycle(0, '0, '0, '0, 32'h0000_0001);
    cycle(0, '0, 14'h3FFF, '0, '0);           // R6: nothing from port A on line 38
    // R2: write, then readback; a strobe-less cycle must not load.
    cycle(1, 32'hFFFF_FFFF, '0, '0, '0);
    @(negedge clk); check_sel(32'hFFFF_FFFF, "R2");
    check_lines(exp_q); exp_valid = 0;
    cycle(0, 32'h1234_5678, 14'h2AAA, 24'hFC_0000, 32'h0);  // R5, R6 with all selected
    cycle(0, 32'h0, '0, 24'hFC_0000, '0);    // R7: upper B pins never reach line 39
    check_sel(32'hFFFF_FFFF, "R2");
    cycle(0, '0, '0, 24'h03_FFFF, 32'hFFFF_FFFF);  // R4 and R7
    // R9: write with inputs steady; old routing must hold for one more cycle.
    cycle(1, 32'h0000_0000, 14'h0001, 24'h00_0001, 32'h8000_0001);
    cycle(0, '0, 14'h0001, 24'h00_0001, 32'h8000_0001);
    cycle(0, '0, 14'h0001, 24'h00_0001, 32'h8000_0001);
    cycle(1, 32'h0000_4000, '0, 24'h00_0001, 32'h0000_4000); // R10 line 14 split
    cycle(0, '0, '0, 24'h00_0001, 32'h0000_4000);

    // Random mix.
    for (int n = 0; n < 400; n++) begin
      logic w;
      w = ($urandom % 6) == 0;
      cycle(w, $urandom, 14'($urandom), 24'($urandom), $urandom);
    end
    cycle(0, '0, '0, '0, '0);
    @(negedge clk); check_lines(exp_q);
    check_sel(model_sel, "R2");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule